// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge and Vector Generator

This block sits between two eight-line interrupt controllers wired as a cascade: the secondary controller's output drives request line 2 of the primary. Each controller has its own priority resolver outside this block. The resolvers supply a winning line number and a valid flag. When the processor issues an acknowledge strobe, this block decides which controller or controllers are being acknowledged. It builds the 8-bit interrupt vector and issues one-cycle strobes that set in-service bits and clear request bits in the controllers' state registers.

An acknowledge can arrive when nothing is pending. Each controller then has its own spurious vector: one for a primary with no winner, and one for a cascade hit when the secondary has no winner. Auto end-of-interrupt clears the in-service bit again one cycle after it was set. It can also rotate the priority base past the acknowledged line. A line in level mode keeps its request bit through the acknowledge. The block also sends the cascade request into primary line 2. In edge mode that request is latched. In level mode it is dropped, because a pulse that goes high and then low leaves nothing behind.

Top module: `casc_ack_vec`

## Requirements
- R1: After reset every output is 0.
- R2: An acknowledge sampled on a clock edge gives vec_vld_o high for exactly the following cycle. When the primary winner w is not line 2, vec_o = {m_base_i[7:3], w} and m_isr_set_o has only bit w set.
- R3: A request-clear strobe is issued for the acknowledged line only if that line's mode bit is 0 (edge). When the mode bit is 1 (level), that bit of the matching irr_clr output stays 0.
- R4: When the primary winner is line 2 and the secondary has a valid winner s, vec_o = {s_base_i[7:3], s}. m_isr_set_o bit 2 and s_isr_set_o bit s are both set, in the same cycle.
- R5: When the primary winner is line 2 and the secondary has no valid winner, vec_o = {s_base_i[7:3], 3'd7}. Only m_isr_set_o bit 2 is set, and every secondary strobe stays 0.
- R6: When the primary has no valid winner, vec_o = {m_base_i[7:3], 3'd7} and no set, clear or rotate strobe is issued.
- R7: When a controller's auto-EOI input is 1, its isr_clr output equals its previous cycle's isr_set output. When auto-EOI is 0, isr_clr stays 0.
- R8: When both auto-EOI and rotate-on-auto-EOI are 1, rot_we_o pulses in the same cycle as isr_set with rot_base_o = (line + 1) mod 8. Otherwise rot_we_o stays 0.
- R9: The low three bits of m_base_i and s_base_i have no effect on vec_o.
- R10: reeval_o pulses in the cycle after each vec_vld_o pulse.
- R11: In the cycle after s_vld_i is high, casc_set_o is 1 when m_lvl_i[2] is 0, and casc_clr_o is 1 when m_lvl_i[2] is 1. Both are 0 after a cycle with s_vld_i low.
- R12: Without an acknowledge, vec_vld_o and all in-service, request and rotate strobes stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ack_i | input | 1 | Acknowledge strobe |
| m_vld_i | input | 1 | Primary has a winner |
| m_win_i | input | 3 | Primary winning line |
| s_vld_i | input | 1 | Secondary has a winner |
| s_win_i | input | 3 | Secondary winning line |
| m_base_i | input | 8 | Primary vector base |
| s_base_i | input | 8 | Secondary vector base |
| m_lvl_i | input | 8 | Primary per-line mode, 1 = level |
| s_lvl_i | input | 8 | Secondary per-line mode, 1 = level |
| m_aeoi_i | input | 1 | Primary auto-EOI enable |
| s_aeoi_i | input | 1 | Secondary auto-EOI enable |
| m_rot_i | input | 1 | Primary rotate-on-auto-EOI |
| s_rot_i | input | 1 | Secondary rotate-on-auto-EOI |
| vec_o | output | 8 | Interrupt vector |
| vec_vld_o | output | 1 | Vector valid pulse |
| reeval_o | output | 1 | Request to re-evaluate the interrupt output |
| m_isr_set_o | output | 8 | Primary in-service set strobe |
| m_isr_clr_o | output | 8 | Primary in-service clear strobe |
| m_irr_clr_o | output | 8 | Primary request clear strobe |
| m_rot_we_o | output | 1 | Primary rotation base write |
| m_rot_base_o | output | 3 | Primary new rotation base |
| s_isr_set_o | output | 8 | Secondary in-service set strobe |
| s_isr_clr_o | output | 8 | Secondary in-service clear strobe |
| s_irr_clr_o | output | 8 | Secondary request clear strobe |
| s_rot_we_o | output | 1 | Secondary rotation base write |
| s_rot_base_o | output | 3 | Secondary new rotation base |
| casc_set_o | output | 1 | Latch the request on primary line 2 |
| casc_clr_o | output | 1 | Drop the request on primary line 2 |

## Verification
The hardest case to reach is an acknowledge of the cascade line while the secondary has no winner. In a running system the secondary's winner would already have raised the cascade request. Because winners and valid flags are driven straight from the bench, the bench can create this case directly. It also crosses that case with the mode bits, and with auto-EOI and rotation on one controller and off on the other. The bench then checks that each controller's strobes follow its own settings. Rotation wrap-around is covered by acknowledging line 7.

// File: rtl/cav_pkg.sv
package cav_pkg;
  localparam int unsigned LINES     = 8;
  localparam int unsigned IDX_W     = $clog2(LINES);
  localparam int unsigned VEC_W     = 8;
  localparam int unsigned CASC_LINE = 2;
  localparam int unsigned SPUR_LINE = LINES - 1;
  localparam int unsigned NCTL      = 2;

  typedef enum logic [1:0] {
    SEL_MASTER = 2'd0,
    SEL_SLAVE  = 2'd1,
    SEL_MSPUR  = 2'd2,
    SEL_SSPUR  = 2'd3
  } src_e;
endpackage

// File: rtl/cav_decide.sv
module cav_decide
  import cav_pkg::*;
#(
  parameter int unsigned N_LINES = LINES,
  parameter int unsigned IW      = $clog2(N_LINES),
  parameter int unsigned VW      = VEC_W,
  parameter int unsigned CASC    = CASC_LINE
) (
  input  logic          ack_i,
  input  logic          m_vld_i,
  input  logic [IW-1:0] m_win_i,
  input  logic          s_vld_i,
  input  logic [IW-1:0] s_win_i,
  input  logic [VW-1:0] m_base_i,
  input  logic [VW-1:0] s_base_i,
  output logic          m_hit_o,
  output logic          s_hit_o,
  output logic [VW-1:0] vec_o,
  output src_e          src_o
);
  localparam logic [IW-1:0] SPUR   = IW'(N_LINES - 1);
  localparam logic [VW-1:0] HI_MSK = {{(VW-IW){1'b1}}, {IW{1'b0}}};

  logic          is_casc;
  logic [IW-1:0] line;
  logic [VW-1:0] base;

  assign is_casc = m_vld_i && (m_win_i == IW'(CASC));

  always_comb begin
    if (!m_vld_i)        src_o = SEL_MSPUR;
    else if (!is_casc)   src_o = SEL_MASTER;
    else if (s_vld_i)    src_o = SEL_SLAVE;
    else                 src_o = SEL_SSPUR;
  end

  always_comb begin
    unique case (src_o)
      SEL_MASTER: begin line = m_win_i; base = m_base_i; end
      SEL_SLAVE:  begin line = s_win_i; base = s_base_i; end
      SEL_SSPUR:  begin line = SPUR;    base = s_base_i; end
      default:    begin line = SPUR;    base = m_base_i; end
    endcase
  end

  // low bits of the base are replaced by the line number
  assign vec_o   = (base & HI_MSK) | VW'(line);
  assign m_hit_o = ack_i && m_vld_i;
  assign s_hit_o = ack_i && (src_o == SEL_SLAVE);
endmodule

// File: rtl/cav_side.sv
module cav_side
  import cav_pkg::*;
#(
  parameter int unsigned N_LINES = LINES,
  parameter int unsigned IW      = $clog2(N_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hit_i,
  input  logic [IW-1:0]      line_i,
  input  logic [N_LINES-1:0] lvl_i,
  input  logic               aeoi_i,
  input  logic               rot_i,
  output logic [N_LINES-1:0] isr_set_o,
  output logic [N_LINES-1:0] isr_clr_o,
  output logic [N_LINES-1:0] irr_clr_o,
  output logic               rot_we_o,
  output logic [IW-1:0]      rot_base_o
);
  logic [N_LINES-1:0] oh;
  logic               aeoi_q;

  assign oh = N_LINES'(1) << line_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_set_o  <= '0;
      isr_clr_o  <= '0;
      irr_clr_o  <= '0;
      rot_we_o   <= 1'b0;
      rot_base_o <= '0;
      aeoi_q     <= 1'b0;
    end else begin
      isr_set_o  <= hit_i ? oh : '0;
      irr_clr_o  <= hit_i ? (oh & ~lvl_i) : '0;
      rot_we_o   <= hit_i && aeoi_i && rot_i;
      rot_base_o <= (hit_i && aeoi_i && rot_i) ? IW'(line_i + 1'b1) : '0;
      aeoi_q     <= aeoi_i;
      // auto-EOI: drop in-service one cycle after it was raised
      isr_clr_o  <= aeoi_q ? isr_set_o : '0;
    end
  end
endmodule

// File: rtl/cav_casc.sv
module cav_casc
  import cav_pkg::*;
#(
  parameter int unsigned N_LINES = LINES,
  parameter int unsigned CASC    = CASC_LINE
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               s_vld_i,
  input  logic [N_LINES-1:0] m_lvl_i,
  output logic               set_o,
  output logic               clr_o
);
  // high-then-low pulse: edge mode keeps the latch, level mode drops it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_o <= 1'b0;
      clr_o <= 1'b0;
    end else begin
      set_o <= s_vld_i && !m_lvl_i[CASC];
      clr_o <= s_vld_i &&  m_lvl_i[CASC];
    end
  end
endmodule

// File: rtl/casc_ack_vec.sv
module casc_ack_vec
  import cav_pkg::*;
#(
  parameter int unsigned N_LINES = LINES,
  parameter int unsigned IW      = $clog2(N_LINES),
  parameter int unsigned VW      = VEC_W,
  parameter int unsigned CASC    = CASC_LINE
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ack_i,
  input  logic               m_vld_i,
  input  logic [IW-1:0]      m_win_i,
  input  logic               s_vld_i,
  input  logic [IW-1:0]      s_win_i,
  input  logic [VW-1:0]      m_base_i,
  input  logic [VW-1:0]      s_base_i,
  input  logic [N_LINES-1:0] m_lvl_i,
  input  logic [N_LINES-1:0] s_lvl_i,
  input  logic               m_aeoi_i,
  input  logic               s_aeoi_i,
  input  logic               m_rot_i,
  input  logic               s_rot_i,
  output logic [VW-1:0]      vec_o,
  output logic               vec_vld_o,
  output logic               reeval_o,
  output logic [N_LINES-1:0] m_isr_set_o,
  output logic [N_LINES-1:0] m_isr_clr_o,
  output logic [N_LINES-1:0] m_irr_clr_o,
  output logic               m_rot_we_o,
  output logic [IW-1:0]      m_rot_base_o,
  output logic [N_LINES-1:0] s_isr_set_o,
  output logic [N_LINES-1:0] s_isr_clr_o,
  output logic [N_LINES-1:0] s_irr_clr_o,
  output logic               s_rot_we_o,
  output logic [IW-1:0]      s_rot_base_o,
  output logic               casc_set_o,
  output logic               casc_clr_o
);
  logic          m_hit, s_hit;
  logic [VW-1:0] vec_d;
  src_e          src;

  logic [NCTL-1:0]    hit_a, aeoi_a, rot_a, rwe_a;
  logic [IW-1:0]      line_a [NCTL];
  logic [N_LINES-1:0] lvl_a  [NCTL];
  logic [N_LINES-1:0] set_a  [NCTL];
  logic [N_LINES-1:0] clr_a  [NCTL];
  logic [N_LINES-1:0] irr_a  [NCTL];
  logic [IW-1:0]      rb_a   [NCTL];

  cav_decide #(.N_LINES(N_LINES), .IW(IW), .VW(VW), .CASC(CASC)) u_dec (
    .ack_i   (ack_i),
    .m_vld_i (m_vld_i),
    .m_win_i (m_win_i),
    .s_vld_i (s_vld_i),
    .s_win_i (s_win_i),
    .m_base_i(m_base_i),
    .s_base_i(s_base_i),
    .m_hit_o (m_hit),
    .s_hit_o (s_hit),
    .vec_o   (vec_d),
    .src_o   (src)
  );

  assign hit_a  = {s_hit, m_hit};
  assign aeoi_a = {s_aeoi_i, m_aeoi_i};
  assign rot_a  = {s_rot_i, m_rot_i};
  assign line_a[0] = m_win_i;
  assign line_a[1] = s_win_i;
  assign lvl_a[0]  = m_lvl_i;
  assign lvl_a[1]  = s_lvl_i;

  for (genvar g = 0; g < NCTL; g++) begin : g_side
    cav_side #(.N_LINES(N_LINES), .IW(IW)) u_side (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hit_i     (hit_a[g]),
      .line_i    (line_a[g]),
      .lvl_i     (lvl_a[g]),
      .aeoi_i    (aeoi_a[g]),
      .rot_i     (rot_a[g]),
      .isr_set_o (set_a[g]),
      .isr_clr_o (clr_a[g]),
      .irr_clr_o (irr_a[g]),
      .rot_we_o  (rwe_a[g]),
      .rot_base_o(rb_a[g])
    );
  end

  assign m_isr_set_o  = set_a[0];
  assign m_isr_clr_o  = clr_a[0];
  assign m_irr_clr_o  = irr_a[0];
  assign m_rot_we_o   = rwe_a[0];
  assign m_rot_base_o = rb_a[0];
  assign s_isr_set_o  = set_a[1];
  assign s_isr_clr_o  = clr_a[1];
  assign s_irr_clr_o  = irr_a[1];
  assign s_rot_we_o   = rwe_a[1];
  assign s_rot_base_o = rb_a[1];

  cav_casc #(.N_LINES(N_LINES), .CASC(CASC)) u_casc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .s_vld_i(s_vld_i),
    .m_lvl_i(m_lvl_i),
    .set_o  (casc_set_o),
    .clr_o  (casc_clr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o     <= '0;
      vec_vld_o <= 1'b0;
      reeval_o  <= 1'b0;
    end else begin
      if (ack_i) vec_o <= vec_d;
      vec_vld_o <= ack_i;
      reeval_o  <= vec_vld_o;
    end
  end

  logic unused_src;
  assign unused_src = ^src;
endmodule

// File: rtl/cav_chk.sv
module cav_chk
  import cav_pkg::*;
#(
  parameter int unsigned N_LINES = LINES
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ack_i,
  input logic [N_LINES-1:0] m_lvl_i,
  input logic               vec_vld_o,
  input logic               reeval_o,
  input logic [N_LINES-1:0] m_isr_set_o,
  input logic [N_LINES-1:0] m_isr_clr_o,
  input logic [N_LINES-1:0] m_irr_clr_o,
  input logic               m_rot_we_o,
  input logic [N_LINES-1:0] s_isr_set_o,
  input logic               casc_set_o,
  input logic               casc_clr_o
);
  a_r2_vld_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> vec_vld_o);
  a_r12_quiet_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> (!vec_vld_o && m_isr_set_o == '0 && s_isr_set_o == '0));
  a_r10_reeval: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld_o |=> reeval_o);
  a_r2_set_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(m_isr_set_o));
  a_r3_level_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (m_irr_clr_o & $past(m_lvl_i)) == '0);
  a_r5_slave_needs_casc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_isr_set_o != '0) |-> m_isr_set_o[CASC_LINE]);
  a_r7_clr_follows_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_isr_clr_o != '0) |-> m_isr_clr_o == $past(m_isr_set_o));
  a_r8_rot_with_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_rot_we_o |-> $countones(m_isr_set_o) == 1);
  a_r11_casc_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(casc_set_o && casc_clr_o));
endmodule

bind casc_ack_vec cav_chk u_chk (.*);

// File: tb/sim_casc_ack_vec.sv
`timescale 1ns/1ps
module sim_casc_ack_vec;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       ack_i = 0, m_vld_i = 0, s_vld_i = 0;
  logic [2:0] m_win_i = 0, s_win_i = 0;
  logic [7:0] m_base_i = 0, s_base_i = 0, m_lvl_i = 0, s_lvl_i = 0;
  logic       m_aeoi_i = 0, s_aeoi_i = 0, m_rot_i = 0, s_rot_i = 0;
  logic [7:0] vec_o, m_isr_set_o, m_isr_clr_o, m_irr_clr_o;
  logic [7:0] s_isr_set_o, s_isr_clr_o, s_irr_clr_o;
  logic       vec_vld_o, reeval_o, m_rot_we_o, s_rot_we_o, casc_set_o, casc_clr_o;
  logic [2:0] m_rot_base_o, s_rot_base_o;

  int n_run = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  casc_ack_vec u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic       mv; logic [2:0] mw; logic sv; logic [2:0] sw;
    logic [7:0] mb, sb, ml, sl, ev, ems, ess;
  } row_t;

  localparam row_t TBL [8] = '{
    '{1'b1, 3'd0, 1'b0, 3'd0, 8'h08, 8'h70, 8'h00, 8'h00, 8'h08, 8'h01, 8'h00},
    '{1'b1, 3'd5, 1'b0, 3'd0, 8'h20, 8'h70, 8'h20, 8'h00, 8'h25, 8'h20, 8'h00},
    '{1'b1, 3'd2, 1'b1, 3'd3, 8'h20, 8'h70, 8'h00, 8'h08, 8'h73, 8'h04, 8'h08},
    '{1'b1, 3'd2, 1'b0, 3'd3, 8'h20, 8'h70, 8'h04, 8'h00, 8'h77, 8'h04, 8'h00},
    '{1'b0, 3'd4, 1'b0, 3'd0, 8'h08, 8'h70, 8'h00, 8'h00, 8'h0F, 8'h00, 8'h00},
    '{1'b1, 3'd1, 1'b0, 3'd0, 8'h27, 8'h70, 8'h00, 8'h00, 8'h21, 8'h02, 8'h00},
    '{1'b1, 3'd2, 1'b1, 3'd6, 8'h08, 8'hA5, 8'h00, 8'h00, 8'hA6, 8'h04, 8'h40},
    '{1'b1, 3'd7, 1'b0, 3'd0, 8'hF8, 8'h70, 8'h00, 8'h00, 8'hFF, 8'h80, 8'h00}
  };

  initial begin
    #200_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #35;
    // R1: reset state
    chk("R1 vld", {31'd0, vec_vld_o}, 0);
    chk("R1 vec", vec_o, 0);
    chk("R1 sets", {m_isr_set_o, s_isr_set_o, m_irr_clr_o, s_irr_clr_o}, 0);
    chk("R1 misc", {reeval_o, casc_set_o, casc_clr_o, m_rot_we_o, s_rot_we_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // table: R2 R3 R4 R5 R6 R9
    foreach (TBL[i]) begin
      @(negedge clk_i);
      m_vld_i = TBL[i].mv; m_win_i = TBL[i].mw; s_vld_i = TBL[i].sv; s_win_i = TBL[i].sw;
      m_base_i = TBL[i].mb; s_base_i = TBL[i].sb; m_lvl_i = TBL[i].ml; s_lvl_i = TBL[i].sl;
      ack_i = 1'b1;
      @(negedge clk_i);
      ack_i = 1'b0;
      chk("R2 vld", {31'd0, vec_vld_o}, 1);
      chk("R2/R4/R5/R6/R9 vec", vec_o, TBL[i].ev);
      chk("R2/R4/R5 m_set", m_isr_set_o, TBL[i].ems);
      chk("R4/R5 s_set", s_isr_set_o, TBL[i].ess);
      chk("R3 m_irr", m_irr_clr_o, TBL[i].ems & ~TBL[i].ml);
      chk("R3 s_irr", s_irr_clr_o, TBL[i].ess & ~TBL[i].sl);
      chk("R6 rot", {m_rot_we_o, s_rot_we_o}, 0);
      @(negedge clk_i);
      chk("R2 vld one cycle", {31'd0, vec_vld_o}, 0);
      chk("R10 reeval", {31'd0, reeval_o}, 1);
      chk("R7 no aeoi clr", {m_isr_clr_o, s_isr_clr_o}, 0);
    end

    // R12: winners present but no acknowledge
    m_vld_i = 1; m_win_i = 3'd3; s_vld_i = 0;
    repeat (2) @(negedge clk_i);
    chk("R12 vld", {31'd0, vec_vld_o}, 0);
    chk("R12 strobes", {m_isr_set_o, m_irr_clr_o, s_isr_set_o, s_irr_clr_o}, 0);
    chk("R12 rot", {m_rot_we_o, s_rot_we_o}, 0);

    // R7 R8: primary auto-EOI with rotation, line 4
    m_aeoi_i = 1; m_rot_i = 1; m_win_i = 3'd4; m_lvl_i = 0; ack_i = 1;
    @(negedge clk_i); ack_i = 0;
    chk("R8 m_rot_we", {31'd0, m_rot_we_o}, 1);
    chk("R8 m_rot_base", m_rot_base_o, 5);
    chk("R7 set", m_isr_set_o, 8'h10);
    chk("R7 no early clr", m_isr_clr_o, 0);
    @(negedge clk_i);
    chk("R7 m_clr", m_isr_clr_o, 8'h10);
    chk("R8 rot one cycle", {31'd0, m_rot_we_o}, 0);

    // R8: wrap at line 7
    m_win_i = 3'd7; ack_i = 1;
    @(negedge clk_i); ack_i = 0;
    chk("R8 wrap we", {31'd0, m_rot_we_o}, 1);
    chk("R8 wrap base", m_rot_base_o, 0);
    @(negedge clk_i);

    // R7 R8: cascade, secondary auto-EOI without rotation, primary plain
    m_aeoi_i = 0; m_rot_i = 0; s_aeoi_i = 1; s_rot_i = 0;
    m_win_i = 3'd2; s_vld_i = 1; s_win_i = 3'd7; s_base_i = 8'h48; ack_i = 1;
    @(negedge clk_i); ack_i = 0; s_vld_i = 0;
    chk("R4 vec", vec_o, 8'h4F);
    chk("R8 s_rot off", {s_rot_we_o, m_rot_we_o}, 0);
    @(negedge clk_i);
    chk("R7 s_clr", s_isr_clr_o, 8'h80);
    chk("R7 m_clr off", m_isr_clr_o, 0);

    // R11: cascade request into primary line 2
    s_aeoi_i = 0; m_vld_i = 0; m_lvl_i = 8'h00; s_vld_i = 1;
    @(negedge clk_i);
    chk("R11 edge set", {casc_set_o, casc_clr_o}, 2'b10);
    m_lvl_i = 8'h04;
    @(negedge clk_i);
    chk("R11 level clr", {casc_set_o, casc_clr_o}, 2'b01);
    s_vld_i = 0;
    @(negedge clk_i);
    chk("R11 idle", {casc_set_o, casc_clr_o}, 2'b00);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule